// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block derives an output clock from a fast internal clock with a phase counter. It gates that clock in response to an asynchronous active-low stop input, and it also produces a companion clock of the same frequency and phase that is never gated. The stop input is first passed through a synchronizer. Every start and stop decision is then taken only at the instant the phase counter enters its low half. As a result, the gated clock always parks low and always resumes with a complete high half-period.

A restart opens an enable window. A stop request that arrives inside the window is held pending and takes effect at the first low-phase boundary after the window closes. A status output marks the span from the first full high pulse after a restart to the last falling edge before a stop. The divide ratio, the window length in output cycles and the synchronizer depth are parameters. The defaults (divide by 8, 10-cycle window, 2 stages) suit a bus-clock setting; a window of 100 serves a processor-clock setting.

Top module: `clk_stop_gate`

## Requirements
- R1: The free clock has a period of DIV fast cycles with a high phase of DIV/2 cycles. It runs whatever the stop input does.
- R2: The stop input passes through SYNC_STAGES flops before use. After a release, the gated clock cannot rise before fast edge SYNC_STAGES+DIV/2+1.
- R3: While stopped, the gated clock is held low.
- R4: Every rising edge of the gated clock coincides with a rising edge of the free clock, so the first pulse after a restart is full width.
- R5: Every high pulse of the gated clock lasts exactly DIV/2 fast cycles, and the gated clock is high only while the free clock is high. The enable changes only at a low-phase boundary.
- R6: With the window expired, after the stop input falls the gated clock and status are both low by fast edge SYNC_STAGES+DIV, and they stay low.
- R7: From stopped, after the stop input rises, the gated clock rises by fast edge SYNC_STAGES+DIV/2+DIV.
- R8: After a restart, at least MIN_ON full high pulses are produced before a stop takes effect. A request inside the window is pending and stops the clock at the first boundary after the window: exactly MIN_ON pulses when synchronized before that boundary, MIN_ON+1 when synchronized one cycle too late.
- R9: The status output rises together with the first gated rising edge after a restart and falls together with the last gated falling edge before a stop.
- R10: During reset the gated clock, free clock and status are low. The first free-clock high pulse after reset is full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| clk_gated_o | output | 1 | Gated output clock |
| clk_free_o | output | 1 | Free-running companion clock |
| running_o | output | 1 | High while the gated clock is delivering pulses |

## Verification
Two events can meet at one low-phase boundary: the end of the minimum-enable window and the arrival of a freshly synchronized stop request. The bench sweeps the moment it drops the stop input across the fast cycles around the boundary that closes the window, one cycle at a time. For each offset it counts the gated pulses until the clock parks. The count must be MIN_ON when the request clears the synchronizer before that boundary and MIN_ON+1 when it clears one cycle late. Throughout the sweep, a monitor confirms that no pulse is shortened.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  // Phase events seen one fast cycle ahead of the output registers
  typedef struct packed {
    logic hi_start;  // next fast cycle opens the high half
    logic lo_start;  // next fast cycle opens the low half
  } phase_evt_t;

endpackage

// File: rtl/cg_phase_gen.sv
module cg_phase_gen
  import clk_gate_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output phase_evt_t evt_o,
  output logic       hi_nxt_o
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Next-state: wrap at DIV-1. Reset parks at LAST so the first
  // edge opens a complete high half.
  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    hi_nxt_o       = (cnt_d < HALF_C);
    evt_o.hi_start = (cnt_d == '0);
    evt_o.lo_start = (cnt_d == HALF_C);
  end

endmodule

// File: rtl/cg_stop_sync.sv
module cg_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n_async,
  output logic stop_req_o
);

  logic [STAGES-1:0] chain_q;

  // Reset value 0 reads as "stop requested", so the clock is
  // enabled only once a released stop input has crossed the chain.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic d;
      if (s == 0) begin : g_first
        assign d = stop_n_async;
      end else begin : g_next
        assign d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= d;
      end
    end
  endgenerate

  assign stop_req_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/cg_gate_ctrl.sv
module cg_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter int MIN_ON = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  phase_evt_t evt_i,
  input  logic       stop_req_i,
  output logic       en_o,
  output logic       run_o
);

  localparam int WW = (MIN_ON > 1) ? $clog2(MIN_ON) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(MIN_ON - 1);

  logic          en_q, en_d;
  logic          run_q, run_d;
  logic [WW-1:0] win_q, win_d;
  logic          win_done;

  // win_q counts completed high pulses minus one; at a boundary the
  // pulse now ending is counted in.
  assign win_done = (win_q >= WIN_LAST);

  always_comb begin
    en_d  = en_q;
    win_d = win_q;
    if (evt_i.lo_start) begin
      if (!en_q) begin
        win_d = '0;
        if (!stop_req_i) en_d = 1'b1;
      end else begin
        if (!win_done) win_d = win_q + 1'b1;
        if (stop_req_i && win_done) en_d = 1'b0;
      end
    end
  end

  always_comb begin
    run_d = run_q;
    if (evt_i.lo_start && !en_d) run_d = 1'b0;
    else if (evt_i.hi_start)     run_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      win_q <= '0;
    end else begin
      en_q  <= en_d;
      run_q <= run_d;
      win_q <= win_d;
    end
  end

  assign en_o  = en_q;
  assign run_o = run_q;

  // R5: enable may only move on the edge that opens a low half
  assert_en_on_boundary_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(evt_i.lo_start)
  );

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_gate_pkg::*;
#(
  parameter int DIV         = 8,
  parameter int MIN_ON      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic stop_n,
  output logic clk_gated_o,
  output logic clk_free_o,
  output logic running_o
);

  localparam int PW = $clog2(MIN_ON + 1);
  localparam logic [PW-1:0] PMAX = PW'(MIN_ON);

  phase_evt_t evt;
  logic       hi_nxt;
  logic       stop_req;
  logic       en;
  logic       run;

  logic gated_q, gated_d;
  logic free_q, free_d;

  cg_phase_gen #(.DIV(DIV)) i_phase (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .evt_o    (evt),
    .hi_nxt_o (hi_nxt)
  );

  cg_stop_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk          (clk_fast),
    .rst_n        (rst_n),
    .stop_n_async (stop_n),
    .stop_req_o   (stop_req)
  );

  cg_gate_ctrl #(.MIN_ON(MIN_ON)) i_ctrl (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .stop_req_i (stop_req),
    .en_o       (en),
    .run_o      (run)
  );

  // Output clocks come straight from flops so they carry no glitches
  always_comb begin
    free_d  = hi_nxt;
    gated_d = hi_nxt & en;
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      free_q  <= 1'b0;
      gated_q <= 1'b0;
    end else begin
      free_q  <= free_d;
      gated_q <= gated_d;
    end
  end

  assign clk_gated_o = gated_q;
  assign clk_free_o  = free_q;
  assign running_o   = run;

  // Pulses since the last restart, kept only for the window check
  logic [PW-1:0] pulses_q;
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) pulses_q <= '0;
    else if (gated_d && !gated_q) begin
      if (!run)                 pulses_q <= PW'(1);
      else if (pulses_q < PMAX) pulses_q <= pulses_q + 1'b1;
    end
  end

  assert_parked_low_R3: assert property (
    @(posedge clk_fast) disable iff (!rst_n)
    !running_o |-> !clk_gated_o
  );

  assert_full_rise_R4: assert property (
    @(posedge clk_fast) disable iff (!rst_n)
    $rose(clk_gated_o) |-> $rose(clk_free_o)
  );

  assert_follow_free_R5: assert property (
    @(posedge clk_fast) disable iff (!rst_n)
    clk_gated_o |-> clk_free_o
  );

  assert_window_R8: assert property (
    @(posedge clk_fast) disable iff (!rst_n)
    $fell(running_o) |-> (pulses_q >= PMAX)
  );

  assert_status_rise_R9: assert property (
    @(posedge clk_fast) disable iff (!rst_n)
    $rose(running_o) |-> $rose(clk_gated_o)
  );

endmodule

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;

  localparam int DIV    = 8;
  localparam int HALF   = DIV / 2;
  localparam int MIN_ON = 10;
  localparam int SYNC   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_n = 1'b0;
  logic gated, free, running;

  int n_checks = 0;
  int n_fail   = 0;
  int rises    = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  clk_stop_gate #(.DIV(DIV), .MIN_ON(MIN_ON), .SYNC_STAGES(SYNC)) i_clk_stop_gate (
    .clk_fast    (clk),
    .rst_n       (rst_n),
    .stop_n      (stop_n),
    .clk_gated_o (gated),
    .clk_free_o  (free),
    .running_o   (running)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Pulse monitor: width, alignment, free period, status
  logic g_prev = 1'b0, f_prev = 1'b0;
  int g_run = 0, f_run = 0;
  bit f_seen = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      g_prev = 1'b0; f_prev = 1'b0; g_run = 0; f_run = 0; f_seen = 1'b0;
    end else begin
      if (gated && !g_prev) begin
        rises++;
        chk(free && !f_prev, "R4 gated rise on free rise", int'(free), 1);
      end
      if (!gated && g_prev) chk(g_run == HALF, "R5 high pulse width", g_run, HALF);
      if (gated && !free) chk(1'b0, "R5 gated high while free low", 1, 0);
      if (gated && !running) chk(1'b0, "R9 status low while pulsing", 0, 1);
      g_run = gated ? (g_prev ? g_run + 1 : 1) : 0;
      if (free != f_prev) begin
        if (f_seen) chk(f_run == HALF, "R1 R10 free half period", f_run, HALF);
        f_seen = 1'b1;
        f_run  = 1;
      end else begin
        f_run++;
      end
      g_prev = gated;
      f_prev = free;
    end
  end

  task automatic park();
    stop_n = 1'b0;
    repeat ((MIN_ON + 3) * DIV) tick();
  endtask

  task automatic t_reset();
    repeat (4) tick();
    chk(!gated && !free && !running, "R10 outputs low in reset",
        int'({gated, free, running}), 0);
    rst_n = 1'b1;
    tick();
    chk(free, "R10 free starts high after reset", int'(free), 1);
  endtask

  task automatic t_hold_stopped();
    int r0, fr;
    bit f0;
    r0 = rises; fr = 0; f0 = free;
    repeat (10 * DIV) begin
      tick();
      if (free && !f0) fr++;
      f0 = free;
    end
    chk(rises == r0 && !gated, "R3 held low while stopped", rises - r0, 0);
    chk(fr == 10, "R1 free keeps running while stopped", fr, 10);
  endtask

  task automatic t_on_latency();
    for (int ph = 0; ph < DIV; ph++) begin
      int n;
      park();
      repeat (ph) tick();
      stop_n = 1'b1;
      n = 0;
      while (!gated && n < 200) begin
        tick();
        n++;
      end
      chk(n >= SYNC + HALF + 1, "R2 no start before sync", n, SYNC + HALF + 1);
      chk(n <= SYNC + HALF + DIV, "R7 on latency bound", n, SYNC + HALF + DIV);
      chk(running, "R9 status rises with first pulse", int'(running), 1);
    end
  endtask

  task automatic t_min_window();
    int r0;
    park();
    stop_n = 1'b1;
    while (!gated) tick();
    r0 = rises - 1;
    stop_n = 1'b0;
    repeat ((MIN_ON + 3) * DIV) tick();
    chk(rises - r0 == MIN_ON, "R8 pending stop waits out window", rises - r0, MIN_ON);
    chk(!running && !gated, "R9 status low after stop", int'(running), 0);
  endtask

  task automatic t_off_latency();
    for (int ph = 0; ph < DIV; ph++) begin
      int r0;
      park();
      stop_n = 1'b1;
      repeat ((MIN_ON + 3) * DIV + ph) tick();
      stop_n = 1'b0;
      repeat (SYNC + DIV) tick();
      chk(!gated && !running, "R6 stopped within off latency",
          int'({gated, running}), 0);
      r0 = rises;
      repeat (3 * DIV) tick();
      chk(rises == r0 && !gated, "R3 stays low after stop", rises - r0, 0);
    end
  endtask

  // Stop request meets the boundary that closes the window
  task automatic t_collision();
    for (int off = HALF + DIV - SYNC - 3; off <= HALF + DIV - SYNC + 1; off++) begin
      int r0, expv;
      park();
      stop_n = 1'b1;
      while (!gated) tick();
      r0 = rises - 1;
      while (rises - r0 < MIN_ON - 1) tick();
      repeat (off) tick();
      stop_n = 1'b0;
      repeat ((MIN_ON + 3) * DIV) tick();
      expv = (off <= HALF + DIV - SYNC - 1) ? MIN_ON : MIN_ON + 1;
      chk(rises - r0 == expv, "R8 window end vs stop arrival", rises - r0, expv);
    end
  endtask

  task automatic t_short_pulse();
    park();
    stop_n = 1'b1;
    repeat ((MIN_ON + 3) * DIV + 3) tick();
    stop_n = 1'b0;
    tick();
    stop_n = 1'b1;
    repeat (4 * DIV) tick();
    chk(gated || running, "R5 clock running after short stop pulse", int'(running), 1);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold_stopped();
    t_on_latency();
    t_min_window();
    t_off_latency();
    t_collision();
    t_short_pulse();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule